// File: doc/BRIEF.md
# SMM Entry and Resume Controller

This block covers the state-save and resume part of a processor's system management mode for two slots of the save area. It holds the revision identifier and the halt-restart flag. When a system management interrupt request arrives outside SMM, the block enters SMM. On that entry it records whether the core was sitting in HALT. It also loads both slots, which sit at fixed offsets from a base address the core supplies.

While in SMM, the handler reads the slots through a simple address/data port. It may set or clear the halt-restart flag. A resume strobe ends SMM. One clock later the block gives a single-cycle decision: either the core goes back into HALT, or it continues at the instruction after the HALT. The block raises an error pulse when the handler has set the flag although the core was not halted at entry. That combination has no defined meaning.

Top module: `smm_state_ctrl`

## Requirements
- R1: After reset, in_smm_o, reenter_halt_o, continue_o and bad_restart_o are 0, and both slots read 0.
- R2: With in_smm_o low, smi_req_i high at a clock edge sets in_smm_o after that edge. With in_smm_o high, smi_req_i has no effect: the halt slot keeps its value even if core_halted_i differs.
- R3: After an entry, a read at byte address smbase_i + 0x7EFC returns the revision word. Bits 15:0 of that word hold the BASE_LEVEL parameter. Bit 16 (I/O trap with restart) is 1. Bit 17 (base and vector relocation) is 1. Bits 31:18 are 0. Writes to this address have no effect.
- R4: A read at byte address smbase_i + 0x7F02 returns the halt slot. Bit 0 is the value of core_halted_i sampled at entry, and bits 31:1 read 0.
- R5: A write (hw_we_i high) to the halt slot address while in_smm_o is high loads hw_wdata_i bit 0 into the slot's bit 0. Halt-slot writes while in_smm_o is low are ignored.
- R6: resume_i high at an edge while in_smm_o is high clears in_smm_o at that edge. In the same cycle it gives a one-cycle pulse: reenter_halt_o if halt slot bit 0 was 1, otherwise continue_o. The decision uses the slot value held before that edge.
- R7: resume_i while in_smm_o is low produces no pulse and leaves in_smm_o low.
- R8: bad_restart_o pulses together with reenter_halt_o when the core was not halted at entry but the slot bit 0 is 1 at resume. Otherwise it stays 0.
- R9: Reads at any address other than the two slots return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smbase_i | input | ADDR_W | Base address of the SMM state area |
| smi_req_i | input | 1 | Request to enter SMM |
| core_halted_i | input | 1 | Core is in HALT (sampled at entry) |
| resume_i | input | 1 | Resume strobe from the handler |
| hw_we_i | input | 1 | Handler write enable |
| hw_addr_i | input | ADDR_W | Handler byte address |
| hw_wdata_i | input | 32 | Handler write data |
| hw_rdata_o | output | 32 | Handler read data (combinational) |
| in_smm_o | output | 1 | High from entry until resume |
| reenter_halt_o | output | 1 | One-cycle pulse: return to HALT |
| continue_o | output | 1 | One-cycle pulse: continue after HALT |
| bad_restart_o | output | 1 | One-cycle pulse: flag set without halt at entry |

## Verification
The properties assume that smbase_i does not change between a read address and the check of its data. They also assume that resume_i and smi_req_i are sampled only at clock edges, and that there are no multi-edge handshakes. The stimulus drives every input on the falling edge and holds it for the whole cycle. This covers base changes, writes that coincide with resume, and requests that arrive inside SMM.

// File: rtl/smm_pkg.sv
package smm_pkg;

    localparam int          WORD_W   = 32;
    localparam logic [15:0] REV_OFS  = 16'h7EFC;
    localparam logic [15:0] HALT_OFS = 16'h7F02;
    localparam logic        HAS_IO_TRAP = 1'b1;
    localparam logic        HAS_RELOC   = 1'b1;

    typedef enum logic { PH_RUN, PH_SMM } phase_e;

    typedef enum logic [1:0] { SEL_NONE, SEL_REV, SEL_HALT } slot_sel_e;

    typedef struct packed {
        logic reenter;
        logic cont;
        logic bad;
    } resume_t;

    function automatic logic [WORD_W-1:0] rev_word(input logic [15:0] level);
        return {14'b0, HAS_RELOC, HAS_IO_TRAP, level};
    endfunction

endpackage

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
    import smm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smi_req_i,
    input  logic resume_i,
    output logic in_smm_o,
    output logic enter_o,
    output logic leave_o
);
    phase_e phase_q;

    assign enter_o  = (phase_q == PH_RUN) && smi_req_i;
    assign leave_o  = (phase_q == PH_SMM) && resume_i;
    assign in_smm_o = (phase_q == PH_SMM);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
        end else if (enter_o) begin
            phase_q <= PH_SMM;
        end else if (leave_o) begin
            phase_q <= PH_RUN;
        end
    end
endmodule

// File: rtl/smm_slot_regs.sv
module smm_slot_regs
    import smm_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [15:0] BASE_LEVEL = 16'h0010
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_i,
    input  logic              in_smm_i,
    input  logic              core_halted_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wbit_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              flag_o,
    output logic              entry_halted_o
);
    localparam logic [ADDR_W-1:0] REV_A  = ADDR_W'(REV_OFS);
    localparam logic [ADDR_W-1:0] HALT_A = ADDR_W'(HALT_OFS);

    logic [WORD_W-1:0] rev_q;
    logic              flag_q;
    logic              entry_q;
    slot_sel_e         sel;

    always_comb begin
        if (addr_i == base_i + REV_A)       sel = SEL_REV;
        else if (addr_i == base_i + HALT_A) sel = SEL_HALT;
        else                                sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rev_q   <= '0;
            flag_q  <= 1'b0;
            entry_q <= 1'b0;
        end else if (enter_i) begin
            rev_q   <= rev_word(BASE_LEVEL);
            flag_q  <= core_halted_i;
            entry_q <= core_halted_i;
        end else if (in_smm_i && we_i && sel == SEL_HALT) begin
            flag_q  <= wbit_i;
        end
    end

    always_comb begin
        case (sel)
            SEL_REV:  rdata_o = rev_q;
            SEL_HALT: rdata_o = {{(WORD_W-1){1'b0}}, flag_q};
            default:  rdata_o = '0;
        endcase
    end

    assign flag_o         = flag_q;
    assign entry_halted_o = entry_q;
endmodule

// File: rtl/smm_resume_dec.sv
module smm_resume_dec
    import smm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    leave_i,
    input  logic    flag_i,
    input  logic    entry_halted_i,
    output resume_t dec_o
);
    resume_t dec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= '0;
            if (leave_i) begin
                dec_q.reenter <= flag_i;
                dec_q.cont    <= ~flag_i;
                dec_q.bad     <= flag_i & ~entry_halted_i;
            end
        end
    end

    assign dec_o = dec_q;
endmodule

// File: rtl/smm_state_ctrl.sv
module smm_state_ctrl
    import smm_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [15:0] BASE_LEVEL = 16'h0010
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] smbase_i,
    input  logic              smi_req_i,
    input  logic              core_halted_i,
    input  logic              resume_i,
    input  logic              hw_we_i,
    input  logic [ADDR_W-1:0] hw_addr_i,
    input  logic [31:0]       hw_wdata_i,
    output logic [31:0]       hw_rdata_o,
    output logic              in_smm_o,
    output logic              reenter_halt_o,
    output logic              continue_o,
    output logic              bad_restart_o
);
    logic    enter, leave, flag, entry_halted;
    resume_t dec;
    logic    unused_wdata;

    assign unused_wdata = ^hw_wdata_i[31:1];

    smm_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .smi_req_i (smi_req_i),
        .resume_i  (resume_i),
        .in_smm_o  (in_smm_o),
        .enter_o   (enter),
        .leave_o   (leave)
    );

    smm_slot_regs #(.ADDR_W(ADDR_W), .BASE_LEVEL(BASE_LEVEL)) u_slots (
        .clk            (clk),
        .rst            (rst),
        .enter_i        (enter),
        .in_smm_i       (in_smm_o),
        .core_halted_i  (core_halted_i),
        .base_i         (smbase_i),
        .we_i           (hw_we_i),
        .addr_i         (hw_addr_i),
        .wbit_i         (hw_wdata_i[0]),
        .rdata_o        (hw_rdata_o),
        .flag_o         (flag),
        .entry_halted_o (entry_halted)
    );

    smm_resume_dec u_dec (
        .clk            (clk),
        .rst            (rst),
        .leave_i        (leave),
        .flag_i         (flag),
        .entry_halted_i (entry_halted),
        .dec_o          (dec)
    );

    assign reenter_halt_o = dec.reenter;
    assign continue_o     = dec.cont;
    assign bad_restart_o  = dec.bad;
endmodule

// File: rtl/smm_state_ctrl_chk.sv
module smm_state_ctrl_chk
    import smm_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [15:0] BASE_LEVEL = 16'h0010
)(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] smbase_i,
    input logic              smi_req_i,
    input logic              resume_i,
    input logic [ADDR_W-1:0] hw_addr_i,
    input logic [31:0]       hw_rdata_o,
    input logic              in_smm_o,
    input logic              reenter_halt_o,
    input logic              continue_o,
    input logic              bad_restart_o
);
    // R2
    smi_enters_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_smm_o && smi_req_i) |=> in_smm_o);

    // R2
    stays_in_smm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_smm_o && !resume_i) |=> in_smm_o);

    // R6
    resume_decides_chk: assert property (@(posedge clk) disable iff (rst)
        (in_smm_o && resume_i) |=> (!in_smm_o && $onehot({reenter_halt_o, continue_o})));

    // R7
    no_stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (reenter_halt_o || continue_o) |-> $past(in_smm_o && resume_i));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_smm_o && !smi_req_i) |=> (!in_smm_o && !reenter_halt_o && !continue_o));

    // R8
    bad_with_reenter_chk: assert property (@(posedge clk) disable iff (rst)
        bad_restart_o |-> reenter_halt_o);

    // R3
    rev_value_chk: assert property (@(posedge clk) disable iff (rst)
        (in_smm_o && hw_addr_i == smbase_i + ADDR_W'(REV_OFS)) |-> hw_rdata_o == rev_word(BASE_LEVEL));

    // R4
    halt_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_addr_i == smbase_i + ADDR_W'(HALT_OFS)) |-> hw_rdata_o[31:1] == '0);
endmodule

bind smm_state_ctrl smm_state_ctrl_chk #(.ADDR_W(ADDR_W), .BASE_LEVEL(BASE_LEVEL)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .smbase_i       (smbase_i),
    .smi_req_i      (smi_req_i),
    .resume_i       (resume_i),
    .hw_addr_i      (hw_addr_i),
    .hw_rdata_o     (hw_rdata_o),
    .in_smm_o       (in_smm_o),
    .reenter_halt_o (reenter_halt_o),
    .continue_o     (continue_o),
    .bad_restart_o  (bad_restart_o)
);

// File: tb/tb_smm_state_ctrl.sv
`timescale 1ns/1ps
module tb_smm_state_ctrl;
    localparam logic [15:0] LEVEL = 16'h0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] smbase = 32'h0003_0000;
    logic        smi = 1'b0, halted = 1'b0, res = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [31:0] rdata;
    logic        in_smm, reenter, cont, bad;

    int total = 0;
    int bad_cnt = 0;

    // Bench model state
    logic m_in = 0, m_flag = 0, m_entry = 0, m_rev = 0;
    logic e_re = 0, e_co = 0, e_bad = 0;

    always #2.5 clk = ~clk;

    smm_state_ctrl #(.ADDR_W(32), .BASE_LEVEL(LEVEL)) dut (
        .clk(clk), .rst(rst), .smbase_i(smbase), .smi_req_i(smi),
        .core_halted_i(halted), .resume_i(res), .hw_we_i(we),
        .hw_addr_i(addr), .hw_wdata_i(wdata), .hw_rdata_o(rdata),
        .in_smm_o(in_smm), .reenter_halt_o(reenter), .continue_o(cont),
        .bad_restart_o(bad)
    );

    function automatic logic [31:0] rev_addr(input logic [31:0] b); return b + 32'h7EFC; endfunction
    function automatic logic [31:0] halt_addr(input logic [31:0] b); return b + 32'h7F02; endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a == rev_addr(smbase))  return m_rev ? (32'h0003_0000 | {16'h0, LEVEL}) : 32'h0;
        if (a == halt_addr(smbase)) return {31'h0, m_flag};
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad_cnt++;
            $display("FAIL %s: got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_read(input logic [31:0] a);
        string tag;
        addr = a;
        we   = 1'b0;
        #1;
        if (a == rev_addr(smbase))       tag = "R3 revision slot";
        else if (a == halt_addr(smbase)) tag = "R4 halt slot";
        else                             tag = "R9 other address";
        chk(tag, rdata, exp_read(a));
    endtask

    // One clock: drive at falling edge, update model, check at next falling edge.
    task automatic cyc(input logic s, input logic r, input logic w,
                       input logic [31:0] a, input logic [31:0] d, input logic h);
        smi = s; res = r; we = w; addr = a; wdata = d; halted = h;
        e_re = 0; e_co = 0; e_bad = 0;
        if (m_in && r) begin
            e_re  = m_flag;
            e_co  = !m_flag;
            e_bad = m_flag && !m_entry;
        end
        if (m_in && w && a == halt_addr(smbase)) m_flag = d[0];
        if (!m_in && s) begin
            m_in = 1; m_rev = 1; m_flag = h; m_entry = h;
        end else if (m_in && r) begin
            m_in = 0;
        end
        @(negedge clk);
        smi = 0; res = 0; we = 0;
        chk("R2/R6/R7 in_smm", {31'h0, in_smm}, {31'h0, m_in});
        chk("R6 reenter_halt", {31'h0, reenter}, {31'h0, e_re});
        chk("R6 continue", {31'h0, cont}, {31'h0, e_co});
        chk("R8 bad_restart", {31'h0, bad}, {31'h0, e_bad});
    endtask

    task automatic idle(); cyc(0, 0, 0, 32'h0, 32'h0, 0); endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad_cnt++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad_cnt);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 in_smm", {31'h0, in_smm}, 32'h0);
        chk("R1 pulses", {29'h0, reenter, cont, bad}, 32'h0);
        chk_read(rev_addr(smbase));
        chk_read(halt_addr(smbase));

        // R7 resume outside SMM, R5 write outside SMM ignored
        cyc(0, 1, 0, 32'h0, 32'h0, 0);
        cyc(0, 0, 1, halt_addr(smbase), 32'h1, 0);
        chk_read(halt_addr(smbase));

        // R2/R3/R4 entry while halted
        cyc(1, 0, 0, 32'h0, 32'h0, 1);
        chk_read(rev_addr(smbase));
        chk_read(halt_addr(smbase));
        chk_read(smbase + 32'h10);
        // R3 writes to revision slot ignored
        cyc(0, 0, 1, rev_addr(smbase), 32'hFFFF_FFFF, 0);
        chk_read(rev_addr(smbase));
        // R2 request inside SMM ignored
        cyc(1, 0, 0, 32'h0, 32'h0, 0);
        chk_read(halt_addr(smbase));
        // R5 clear the flag, R6 resume -> continue
        cyc(0, 0, 1, halt_addr(smbase), 32'hFFFF_FFFE, 0);
        chk_read(halt_addr(smbase));
        cyc(0, 1, 0, 32'h0, 32'h0, 0);
        idle();

        // R8 entry not halted, handler sets flag, resume -> reenter + error
        cyc(1, 0, 0, 32'h0, 32'h0, 0);
        chk_read(halt_addr(smbase));
        cyc(0, 0, 1, halt_addr(smbase), 32'h1, 0);
        cyc(0, 1, 0, 32'h0, 32'h0, 0);
        idle();

        // R6 entry halted, flag kept -> reenter without error
        cyc(1, 0, 0, 32'h0, 32'h0, 1);
        cyc(0, 1, 1, halt_addr(smbase), 32'h0, 0);
        idle();
        chk_read(halt_addr(smbase));

        // Constrained random phase
        for (int i = 0; i < 2000; i++) begin
            int unsigned op = $urandom % 8;
            logic [31:0] a;
            if ($urandom % 16 == 0) smbase = $urandom;
            case ($urandom % 3)
                0: a = rev_addr(smbase);
                1: a = halt_addr(smbase);
                default: a = $urandom;
            endcase
            case (op)
                0, 1: cyc(1, 0, 0, 32'h0, 32'h0, 1'($urandom));
                2:    cyc(0, 1, 1'($urandom), halt_addr(smbase), $urandom, 0);
                3, 4: cyc(0, 0, 1, halt_addr(smbase), $urandom, 0);
                5:    cyc(0, 0, 1, rev_addr(smbase), $urandom, 0);
                6:    cyc(1'($urandom), 1'($urandom), 1, $urandom, $urandom, 1'($urandom));
                default: idle();
            endcase
            chk_read(a);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad_cnt);
        $finish;
    end
endmodule